// File: doc/BRIEF.md
# Integer Execute Unit with Split-Width Carry and Overflow Flags

This block is the arithmetic slice of a scalar processor's execute stage. Each transaction carries two 64-bit operands, a carry-in, a 2-bit operation code, a byte-length field and a flag that selects 32-bit mode. The unit returns a 64-bit result, carry and overflow flags taken at both the 64-bit and the 32-bit boundary, a 4-bit condition field, and four write strobes. The strobes tell the write-back logic which of the outputs must be written: the result, the condition field, the overflow pair and the carry pair.

Three operations are supported. The first is add-with-carry. The second sign-extends a byte, halfword or word of operand A. The third is a byte-equality search: the low byte of A is compared with every byte of B, and a condition bit is set on any match. Operation code 3 is invalid. It produces nothing and raises no strobe.

Transactions enter and leave on valid/ready handshakes. A transfer occurs on a rising clock edge where both valid and ready are high. With the output register enabled (`OUT_REG=1`), `in_ready` is high whenever the output slot is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, every output holds its value. With `OUT_REG=0` the path is combinational: `out_valid` follows `in_valid`, and `in_ready` follows `out_ready`.

Top module: `alu_flagged_exec`

## Requirements
- R1: For operation code 0 (add), the 65-bit value {out_carry64, out_result} equals A + B + in_cin.
- R2: For add, out_carry32 is bit 32 of the sum of A[31:0], B[31:0] and in_cin.
- R3: For add, out_ovf64 = (out_carry64 XOR result[63]) AND NOT (A[63] XOR B[63]), and out_ovf32 = (out_carry32 XOR result[31]) AND NOT (A[31] XOR B[31]).
- R4: For operation code 1 (sign extend), an in_len of 1, 2 or 4 copies the low 8, 16 or 32 bits of A into the result, and every higher bit repeats the top bit of that field. Any other in_len value passes A through unchanged.
- R5: For operation code 2 (byte compare), out_cond[2] is 1 exactly when A[7:0] equals at least one of the eight bytes of B. out_cond bits 3, 1 and 0 are 0, and the result is zero.
- R6: out_res_wr is 1 for operation codes 0, 1 and 2 and is 0 for code 3. out_cond_wr is 1 only for code 2. out_ovf_wr and out_cry_wr are 1 only for code 0. Every flag and condition bit whose strobe is low is 0, and the result is 0 for code 3.
- R7: When in_mode32 is 1, bits 63:32 of both operands are treated as zero by every operation.
- R8: With OUT_REG=1, in_ready equals NOT out_valid OR out_ready. While out_valid is high and out_ready is low, out_valid stays high on the next cycle and all outputs keep their values. Transactions leave in the order they entered.
- R9: While rst_n is low, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input transaction present |
| in_ready | output | 1 | Unit can accept the input this cycle |
| in_op | input | 2 | 0 add, 1 sign extend, 2 byte compare, 3 invalid |
| in_a | input | 64 | Operand A |
| in_b | input | 64 | Operand B |
| in_cin | input | 1 | Carry-in for add |
| in_len | input | 4 | Byte length for sign extend (1, 2, 4) |
| in_mode32 | input | 1 | 32-bit mode: upper operand halves read as zero |
| out_valid | output | 1 | Output transaction present |
| out_ready | input | 1 | Consumer accepts the output |
| out_result | output | 64 | Result |
| out_carry64 | output | 1 | Carry out of bit 63 |
| out_carry32 | output | 1 | Carry out of bit 31 |
| out_ovf64 | output | 1 | Signed overflow at 64 bits |
| out_ovf32 | output | 1 | Signed overflow at 32 bits |
| out_cond | output | 4 | Condition field; bit 2 is byte-match |
| out_res_wr | output | 1 | Result must be written back |
| out_cond_wr | output | 1 | Condition field must be written back |
| out_ovf_wr | output | 1 | Overflow pair must be written back |
| out_cry_wr | output | 1 | Carry pair must be written back |

## Verification
The bench builds the unit with `W=64` and `OUT_REG=1`, the registered variant. This exposes the back-pressure path: stalls held over several cycles, in_ready falling while the slot is full, and the ordering of queued results against the model. The 64-bit width brings carry and overflow at both boundaries within reach, together with sign extension at each length and a byte match in every lane. Random traffic mixes all four operation codes, both modes and irregular out_ready patterns.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [1:0] {
    OPC_ADD  = 2'd0,
    OPC_SEXT = 2'd1,
    OPC_BEQ  = 2'd2,
    OPC_RSVD = 2'd3
  } opc_e;

  typedef struct packed {
    logic c64;
    logic c32;
    logic o64;
    logic o32;
  } flag_t;

  typedef struct packed {
    logic res;
    logic cond;
    logic ovf;
    logic cry;
  } wr_t;

  localparam int COND_W   = 4;
  localparam int MATCH_BIT = 2;
endpackage

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int W = 64
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         c_hi,
  output logic         c_lo,
  output logic         ov_hi,
  output logic         ov_lo
);
  localparam int H = W / 2;
  logic [W:0] full;

  always_comb begin
    full  = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    sum   = full[W-1:0];
    c_hi  = full[W];
    // carry into bit H equals carry out of the low half
    c_lo  = full[H] ^ a[H] ^ b[H];
    ov_hi = (c_hi ^ full[W-1]) & ~(a[W-1] ^ b[W-1]);
    ov_lo = (c_lo ^ full[H-1]) & ~(a[H-1] ^ b[H-1]);
  end

  always_comb begin
    if (a == '0 && b == '0) begin
      assert_zero_add_R1: assert (sum == {{(W-1){1'b0}}, cin} && !c_hi && !c_lo);
    end
    if (a[W-1] != b[W-1]) begin
      assert_mixed_sign_R3: assert (!ov_hi);
    end
  end
endmodule

// File: rtl/alu_sext.sv
module alu_sext #(
  parameter int W = 64
) (
  input  logic [W-1:0] a,
  input  logic [3:0]   len,
  output logic [W-1:0] y
);
  localparam int NLEN = 3;
  logic [W-1:0] ext [NLEN];

  for (genvar k = 0; k < NLEN; k++) begin : g_len
    localparam int BW = 8 << k;
    assign ext[k] = {{(W-BW){a[BW-1]}}, a[BW-1:0]};
  end

  always_comb begin
    unique case (len)
      4'd1:    y = ext[0];
      4'd2:    y = ext[1];
      4'd4:    y = ext[2];
      default: y = a;
    endcase
  end

  always_comb begin
    if (len == 4'd1) begin
      assert_sext_fill_R4: assert ($countones(y[W-1:7]) == 0 || $countones(y[W-1:7]) == W-7);
    end
    if (len == 4'd4) begin
      assert_sext_low_R4: assert (y[31:0] == a[31:0]);
    end
  end
endmodule

// File: rtl/alu_bytecmp.sv
module alu_bytecmp #(
  parameter int W = 64
) (
  input  logic [7:0]   key,
  input  logic [W-1:0] b,
  output logic         hit
);
  localparam int NB = W / 8;
  logic [NB-1:0] lane_eq;

  for (genvar i = 0; i < NB; i++) begin : g_lane
    assign lane_eq[i] = (b[i*8 +: 8] == key);
  end

  assign hit = |lane_eq;

  always_comb begin
    if (b[W-1 -: 8] == key) begin
      assert_top_lane_R5: assert (hit);
    end
  end
endmodule

// File: rtl/alu_flagged_exec.sv
module alu_flagged_exec #(
  parameter int W       = 64,
  parameter bit OUT_REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [1:0]   in_op,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic         in_cin,
  input  logic [3:0]   in_len,
  input  logic         in_mode32,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_result,
  output logic         out_carry64,
  output logic         out_carry32,
  output logic         out_ovf64,
  output logic         out_ovf32,
  output logic [3:0]   out_cond,
  output logic         out_res_wr,
  output logic         out_cond_wr,
  output logic         out_ovf_wr,
  output logic         out_cry_wr
);
  import alu_pkg::*;
  localparam int H = W / 2;

  logic [W-1:0] am, bm;
  logic [W-1:0] add_sum, sext_y;
  logic         c_hi, c_lo, ov_hi, ov_lo, hit;

  logic [W-1:0]      n_res;
  flag_t             n_flg;
  logic [COND_W-1:0] n_cond;
  wr_t               n_wr;

  assign am = in_mode32 ? {{H{1'b0}}, in_a[H-1:0]} : in_a;
  assign bm = in_mode32 ? {{H{1'b0}}, in_b[H-1:0]} : in_b;

  alu_adder #(.W(W)) u_add (
    .a(am), .b(bm), .cin(in_cin), .sum(add_sum),
    .c_hi(c_hi), .c_lo(c_lo), .ov_hi(ov_hi), .ov_lo(ov_lo)
  );

  alu_sext #(.W(W)) u_sext (.a(am), .len(in_len), .y(sext_y));

  alu_bytecmp #(.W(W)) u_cmp (.key(am[7:0]), .b(bm), .hit(hit));

  always_comb begin
    n_res  = '0;
    n_flg  = '0;
    n_cond = '0;
    n_wr   = '0;
    case (opc_e'(in_op))
      OPC_ADD: begin
        n_res  = add_sum;
        n_flg  = '{c64: c_hi, c32: c_lo, o64: ov_hi, o32: ov_lo};
        n_wr   = '{res: 1'b1, cond: 1'b0, ovf: 1'b1, cry: 1'b1};
      end
      OPC_SEXT: begin
        n_res  = sext_y;
        n_wr   = '{res: 1'b1, cond: 1'b0, ovf: 1'b0, cry: 1'b0};
      end
      OPC_BEQ: begin
        n_cond[MATCH_BIT] = hit;
        n_wr   = '{res: 1'b1, cond: 1'b1, ovf: 1'b0, cry: 1'b0};
      end
      default: ;
    endcase
  end

  logic [W-1:0]      q_res;
  flag_t             q_flg;
  logic [COND_W-1:0] q_cond;
  wr_t               q_wr;

  if (OUT_REG) begin : g_reg
    logic q_vld;
    assign in_ready = !q_vld || out_ready;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q_vld  <= 1'b0;
        q_res  <= '0;
        q_flg  <= '0;
        q_cond <= '0;
        q_wr   <= '0;
      end else if (in_ready) begin
        q_vld <= in_valid;
        if (in_valid) begin
          q_res  <= n_res;
          q_flg  <= n_flg;
          q_cond <= n_cond;
          q_wr   <= n_wr;
        end
      end
    end
    assign out_valid = q_vld;

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_result) &&
        $stable(out_cond) && $stable(q_flg) && $stable(q_wr));
    assert_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !in_ready |-> out_valid && !out_ready);
  end else begin : g_comb
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign q_res  = n_res;
    assign q_flg  = n_flg;
    assign q_cond = n_cond;
    assign q_wr   = n_wr;
  end

  assign out_result  = q_res;
  assign out_carry64 = q_flg.c64;
  assign out_carry32 = q_flg.c32;
  assign out_ovf64   = q_flg.o64;
  assign out_ovf32   = q_flg.o32;
  assign out_cond    = q_cond;
  assign out_res_wr  = q_wr.res;
  assign out_cond_wr = q_wr.cond;
  assign out_ovf_wr  = q_wr.ovf;
  assign out_cry_wr  = q_wr.cry;

  assert_strobe_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_res_wr |-> !out_cond_wr && !out_ovf_wr && !out_cry_wr && out_result == '0);
  assert_flag_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_cry_wr |-> !out_carry64 && !out_carry32 && !out_ovf64 && !out_ovf32);
  assert_cond_shape_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_cond_wr |-> !out_cond[3] && !out_cond[1] && !out_cond[0] && !out_ovf_wr);
endmodule

// File: tb/sim_alu_flagged_exec.sv
module sim_alu_flagged_exec;
  localparam int W = 64;

  typedef struct packed {
    logic [W-1:0] res;
    logic c64, c32, o64, o32;
    logic [3:0] cond;
    logic [3:0] wr;
    logic m32;
    logic [1:0] op;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [1:0] in_op = '0;
  logic [W-1:0] in_a = '0, in_b = '0;
  logic in_cin = 1'b0, in_mode32 = 1'b0;
  logic [3:0] in_len = '0;
  logic out_valid, out_ready = 1'b1;
  logic [W-1:0] out_result;
  logic out_carry64, out_carry32, out_ovf64, out_ovf32;
  logic [3:0] out_cond;
  logic out_res_wr, out_cond_wr, out_ovf_wr, out_cry_wr;

  int checks = 0, errors = 0, cycles = 0;
  int ready_mode = 0;
  exp_t q[$];
  logic held = 1'b0;
  logic [W-1:0] held_res;
  logic [3:0] held_cond;

  always #5 clk = ~clk;

  alu_flagged_exec #(.W(W), .OUT_REG(1'b1)) u0 (.*);

  function automatic exp_t model(logic [1:0] op, logic [W-1:0] a, logic [W-1:0] b,
                                 logic cin, logic [3:0] len, logic m32);
    exp_t e;
    logic [64:0] s65;
    logic [32:0] s33;
    int nb;
    e = '0;
    e.m32 = m32;
    e.op = op;
    if (m32) begin
      a[63:32] = '0;
      b[63:32] = '0;
    end
    case (op)
      2'd0: begin
        s65 = {1'b0, a} + {1'b0, b} + 65'(cin);
        s33 = {1'b0, a[31:0]} + {1'b0, b[31:0]} + 33'(cin);
        e.res = s65[63:0];
        e.c64 = s65[64];
        e.c32 = s33[32];
        e.o64 = (e.c64 ^ e.res[63]) & ~(a[63] ^ b[63]);
        e.o32 = (e.c32 ^ e.res[31]) & ~(a[31] ^ b[31]);
        e.wr = 4'b1011;
      end
      2'd1: begin
        nb = (len == 4'd1 || len == 4'd2 || len == 4'd4) ? int'(len) : 0;
        for (int i = 0; i < W; i++)
          e.res[i] = (nb == 0 || i < nb * 8) ? a[i] : a[nb * 8 - 1];
        e.wr = 4'b1000;
      end
      2'd2: begin
        for (int i = 0; i < 8; i++)
          if (b[i*8 +: 8] == a[7:0]) e.cond = 4'b0100;
        e.wr = 4'b1100;
      end
      default: e = '0;
    endcase
    return e;
  endfunction

  task automatic chk(logic ok, string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic send(logic [1:0] op, logic [W-1:0] a, logic [W-1:0] b,
                      logic cin, logic [3:0] len, logic m32);
    logic fired;
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b;
    in_cin = cin; in_len = len; in_mode32 = m32;
    do begin
      @(negedge clk);
      fired = in_ready;
      @(posedge clk);
      #2;
    end while (!fired);
    in_valid = 1'b0;
  endtask

  always @(posedge clk) begin
    #2;
    case (ready_mode)
      0: out_ready = 1'b1;
      1: out_ready = ($urandom % 3) != 0;
      default: out_ready = 1'b0;
    endcase
  end

  always @(negedge clk) begin
    exp_t e;
    if (!rst_n) begin
      chk(!out_valid, "R9 out_valid in reset", W'(out_valid), 0);
      chk(in_ready, "R9 in_ready in reset", W'(in_ready), 1);
    end else begin
      cycles++;
      if (held) begin
        chk(out_valid && out_result == held_res && out_cond == held_cond,
            "R8 hold under stall", out_result, held_res);
      end
      held = out_valid && !out_ready;
      held_res = out_result;
      held_cond = out_cond;
      chk(in_ready == (!out_valid || out_ready), "R8 in_ready rule",
          W'(in_ready), W'(!out_valid || out_ready));
      if (out_valid && out_ready) begin
        if (q.size() == 0) begin
          chk(1'b0, "R8 unexpected output", W'(1), 0);
        end else begin
          e = q.pop_front();
          case (e.op)
            2'd0: chk(out_result == e.res && out_carry64 == e.c64,
                      e.m32 ? "R7 add result" : "R1 add result", out_result, e.res);
            2'd1: chk(out_result == e.res, e.m32 ? "R7 sext result" : "R4 sext result",
                      out_result, e.res);
            2'd2: chk(out_result == e.res && out_cond == e.cond, "R5 byte compare",
                      {out_result[59:0], out_cond}, {e.res[59:0], e.cond});
            default: chk(out_result == '0, "R6 invalid op result", out_result, 0);
          endcase
          chk(out_carry64 == e.c64 && out_carry32 == e.c32, "R2 carries",
              W'({out_carry64, out_carry32}), W'({e.c64, e.c32}));
          chk(out_ovf64 == e.o64 && out_ovf32 == e.o32, "R3 overflows",
              W'({out_ovf64, out_ovf32}), W'({e.o64, e.o32}));
          chk({out_res_wr, out_cond_wr, out_ovf_wr, out_cry_wr} == e.wr, "R6 strobes",
              W'({out_res_wr, out_cond_wr, out_ovf_wr, out_cry_wr}), W'(e.wr));
        end
      end
      if (in_valid && in_ready)
        q.push_back(model(in_op, in_a, in_b, in_cin, in_len, in_mode32));
    end
  end

  always @(posedge clk) begin
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=%0d", cycles, 100000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(posedge clk); #2;
    // R1/R2/R3 directed adds
    send(2'd0, '1, 64'd0, 1'b1, 4'd0, 1'b0);
    send(2'd0, 64'h7fff_ffff_ffff_ffff, 64'd1, 1'b0, 4'd0, 1'b0);
    send(2'd0, 64'h0000_0000_7fff_ffff, 64'd1, 1'b0, 4'd0, 1'b0);
    send(2'd0, 64'h8000_0000_8000_0000, 64'h8000_0000_8000_0000, 1'b0, 4'd0, 1'b0);
    // R7 upper halves ignored
    send(2'd0, 64'hdead_beef_ffff_ffff, 64'h1234_5678_0000_0000, 1'b1, 4'd0, 1'b1);
    // R4 each length and pass-through
    send(2'd1, 64'h0123_4567_89ab_cd80, '0, 1'b0, 4'd1, 1'b0);
    send(2'd1, 64'hffff_ffff_ffff_7f7f, '0, 1'b0, 4'd1, 1'b0);
    send(2'd1, 64'h0000_0000_0000_8001, '0, 1'b0, 4'd2, 1'b0);
    send(2'd1, 64'h0000_0000_8000_0001, '0, 1'b0, 4'd4, 1'b0);
    send(2'd1, 64'h8765_4321_0000_0001, '0, 1'b0, 4'd8, 1'b0);
    send(2'd1, 64'hffff_ffff_8000_0000, '0, 1'b0, 4'd8, 1'b1);
    // R5 compare lanes
    send(2'd2, 64'h0000_0000_0000_00a5, 64'ha511_2233_4455_6677, 1'b0, 4'd0, 1'b0);
    send(2'd2, 64'h0000_0000_0000_00a5, 64'h1122_3344_5566_7788, 1'b0, 4'd0, 1'b0);
    send(2'd2, 64'h0000_0000_0000_0000, 64'h1111_1111_1111_1100, 1'b0, 4'd0, 1'b0);
    send(2'd2, 64'h0000_0000_0000_0055, 64'h5500_0000_1111_1111, 1'b0, 4'd0, 1'b1);
    // R6 invalid code
    send(2'd3, '1, '1, 1'b1, 4'd1, 1'b0);
    // R8 long stall then drain
    ready_mode = 2;
    send(2'd0, 64'd5, 64'd6, 1'b0, 4'd0, 1'b0);
    fork
      send(2'd1, 64'h80, '0, 1'b0, 4'd1, 1'b0);
      begin repeat (6) @(posedge clk); ready_mode = 0; end
    join
    ready_mode = 1;
    for (int n = 0; n < 600; n++) begin
      logic [W-1:0] ra, rb;
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      if (($urandom % 4) == 0) rb[15:8] = ra[7:0];
      send(2'($urandom), ra, rb, 1'($urandom), 4'($urandom % 9), 1'($urandom));
    end
    ready_mode = 0;
    repeat (5) @(posedge clk);
    chk(q.size() == 0, "R8 all results delivered", W'(q.size()), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule